// File: doc/BRIEF.md
# Dual-Channel Storage Address Decoder

This block sits between a host I/O port and a two-channel disk interface. It holds five programmable base addresses: a command window and a control window for each channel, plus one shared bus-master window. Each host access goes through a small state machine. The machine decodes the address into a region, a channel, a local offset and a target drive slot. It then performs the access as transfers on a drive-side port or a bus-master-side port, and ends with a one-cycle completion pulse that carries the read data and the decode results.

Each channel has one drive-select bit. The bit is captured from byte writes to the select register in that channel's command window. The target drive slot is twice the channel number plus that bit, which gives four slots. Two host command bits gate the accesses. Bit 0 (I/O enable) gates every access. Bit 2 (bus-master enable) gates writes to the bus-master window only. An address outside all windows, or an access size that the target register does not accept, sets a sticky error flag and reads back as all-ones.

The state machine has six states. `ST_IDLE` accepts a request. `ST_DECODE` resolves the window, the gating and the size rules, and updates the select bit. `ST_DRV_LO` makes the first or only 16-bit drive transfer. `ST_DRV_HI` makes the second half of a 4-byte data-register access. `ST_BM` makes a single bus-master transfer. `ST_DONE` pulses completion. The transitions are:
- `ST_IDLE` goes to `ST_DECODE` when a request arrives.
- `ST_DECODE` goes to `ST_DRV_LO`, `ST_BM` or `ST_DONE`, depending on whether the access needs a transfer and which side it targets.
- `ST_DRV_LO` goes to `ST_DRV_HI` for a 4-byte data access, and to `ST_DONE` otherwise.
- `ST_DRV_HI` and `ST_BM` go to `ST_DONE`.
- `ST_DONE` returns to `ST_IDLE`.

Top module: `stor_io_decoder`

## Requirements
- R1: After reset `acc_ready` is 1, `dec_err` is 0, no drive or bus-master transfer is active, all five base addresses are 0 and both drive-select bits are 0.
- R2: The windows are checked in this order: primary command (size 8), primary control (size 4), secondary command (size 8), secondary control (size 4), bus-master (size 16). An address hits a window when base <= address < base + size, and the first window that hits wins. `acc_offset` is the address minus that window's base. The region code is 1 for command, 2 for control and 3 for bus-master.
- R3: A base write (`base_idx` 0..4, in the window order of R2) with a value of zero leaves the base unchanged. A nonzero value replaces the base.
- R4: In the bus-master window, offsets below 8 belong to channel 0 and offsets of 8 or more belong to channel 1.
- R5: A 1-byte write to offset 6 of a command window, with I/O enabled, sets that channel's select bit to data bit 4. Each channel keeps its own bit. The drive slot is 2 x channel + select bit, and the write itself already targets the new slot.
- R6: When `host_cmd` bit 0 is 0, an access that hits a window makes no transfer, reads 0 and does not change the select bits.
- R7: When `host_cmd` bit 2 is 0, bus-master-window writes are dropped with no transfer. Bus-master reads still pass.
- R8: An access to a drive slot whose `drv_present` bit is 0 makes no transfer and reads 0.
- R9: The data register is command-window offset 0. A 2-byte access makes one drive transfer. A 4-byte access makes two transfers: the low half (`dx_half`=0, data bits 15:0) first, then the high half (`dx_half`=1, bits 31:16).
- R10: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=illegal. The data register takes codes 1 and 2. The other drive registers take code 0. The bus-master window takes codes 0 to 2. Any other combination makes no transfer, reads all-ones and sets `dec_err`.
- R11: An address that hits no window reports region 0, reads all-ones and sets `dec_err`. `dec_err` then stays 1 until reset.
- R12: A request is accepted only while `acc_ready` is 1. `acc_ready` stays 0 until exactly one `acc_done` pulse has been given for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd | input | 16 | Host command word; bit 0 is I/O enable, bit 2 is bus-master enable |
| base_wr | input | 1 | Base-address write strobe |
| base_idx | input | 3 | Window selected for the base write (0..4) |
| base_val | input | ADDR_W | New base address |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Block is idle and can accept a request |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W | Access address |
| acc_size | input | 2 | Size code |
| acc_wdata | input | 32 | Write data |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_rdata | output | 32 | Read data, valid with `acc_done` |
| acc_region | output | 2 | Decoded region |
| acc_chan | output | 1 | Decoded channel |
| acc_offset | output | OFF_W | Offset inside the window |
| acc_drive | output | 2 | Target drive slot |
| dec_err | output | 1 | Sticky decode/size error |
| drv_present | input | 4 | One bit per drive slot that has a drive |
| dx_valid | output | 1 | Drive transfer strobe |
| dx_write | output | 1 | Drive transfer direction |
| dx_half | output | 1 | Second 16-bit half of a 4-byte access |
| dx_drive | output | 2 | Drive slot of the transfer |
| dx_region | output | 2 | Region of the transfer (command or control) |
| dx_offset | output | OFF_W | Register offset of the transfer |
| dx_wdata | output | 16 | Drive write data |
| dx_rdata | input | 16 | Drive read data, sampled while `dx_valid` is 1 |
| bm_valid | output | 1 | Bus-master register transfer strobe |
| bm_write | output | 1 | Bus-master transfer direction |
| bm_chan | output | 1 | Channel that owns the bus-master offset |
| bm_offset | output | OFF_W | Offset inside the bus-master window |
| bm_size | output | 2 | Size code of the bus-master transfer |
| bm_wdata | output | 32 | Bus-master write data |
| bm_rdata | input | 32 | Bus-master read data, sampled while `bm_valid` is 1 |

## Verification
Before any base is programmed, all five windows sit on top of each other at address 0. Addresses there show whether the stated window order really decides the winner, and an address that only the larger bus-master window covers shows the offset split between channels. Once the bases are programmed, the tests cover several kinds of access:
- select-register writes with bit 4 set and cleared on each channel, which show per-channel independence and the 2 x channel + select slot rule;
- data-register accesses of 2 and 4 bytes, which show the one-transfer and the two-transfer split with its half order;
- accesses with I/O disabled, with bus mastering disabled, to an empty slot, with an illegal size and to an unmapped address, each told apart by its transfer count and its read value (zero or all-ones).

// File: rtl/stor_dec_pkg.sv
package stor_dec_pkg;

    localparam int NUM_WIN = 5;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CMD  = 2'd1,
        RGN_CTL  = 2'd2,
        RGN_BM   = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DECODE = 3'd1,
        ST_DRV_LO = 3'd2,
        ST_DRV_HI = 3'd3,
        ST_BM     = 3'd4,
        ST_DONE   = 3'd5
    } state_e;

    localparam logic [1:0] SZ_1 = 2'd0;
    localparam logic [1:0] SZ_2 = 2'd1;
    localparam logic [1:0] SZ_4 = 2'd2;

    // Window index -> region; order 0..4 is the match priority
    function automatic region_e win_region(input int w);
        case (w)
            0, 2:    return RGN_CMD;
            1, 3:    return RGN_CTL;
            default: return RGN_BM;
        endcase
    endfunction

    function automatic logic win_chan(input int w);
        return (w == 2 || w == 3);
    endfunction

endpackage

// File: rtl/stor_win_decode.sv
module stor_win_decode
    import stor_dec_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CMD_SIZE = 8,
    parameter int CTL_SIZE = 4,
    parameter int BM_SIZE  = 16,
    parameter int BM_SPLIT = 8,
    parameter int OFF_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [2:0]        base_idx,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              hit,
    output region_e           region,
    output logic              chan,
    output logic [OFF_W-1:0]  offset
);

    function automatic int win_size(input int w);
        case (w)
            0, 2:    return CMD_SIZE;
            1, 3:    return CTL_SIZE;
            default: return BM_SIZE;
        endcase
    endfunction

    logic [NUM_WIN-1:0]             hit_vec;
    logic [NUM_WIN-1:0][ADDR_W-1:0] off_vec;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic [ADDR_W-1:0] base_r;
        logic [ADDR_W:0]   lo_ext;
        logic [ADDR_W:0]   hi_ext;
        logic [ADDR_W:0]   a_ext;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                base_r <= '0;
            else if (base_wr && base_idx == 3'(w) && base_val != '0)
                base_r <= base_val;
        end

        assign lo_ext     = {1'b0, base_r};
        assign hi_ext     = lo_ext + (ADDR_W+1)'(win_size(w));
        assign a_ext      = {1'b0, lookup_addr};
        assign hit_vec[w] = (a_ext >= lo_ext) && (a_ext < hi_ext);
        assign off_vec[w] = lookup_addr - base_r;
    end

    always_comb begin
        hit    = 1'b0;
        region = RGN_NONE;
        chan   = 1'b0;
        offset = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit    = 1'b1;
                region = win_region(w);
                offset = off_vec[w][OFF_W-1:0];
                if (win_region(w) == RGN_BM)
                    chan = (off_vec[w][OFF_W-1:0] >= OFF_W'(BM_SPLIT));
                else
                    chan = win_chan(w);
            end
        end
    end

endmodule

// File: rtl/stor_drv_select.sv
module stor_drv_select #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              upd_chan,
    input  logic              upd_val,
    output logic [NUM_CH-1:0] sel_q
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sel_q[c] <= 1'b0;
            else if (upd && int'(upd_chan) == c)
                sel_q[c] <= upd_val;
        end
    end

endmodule

// File: rtl/stor_io_decoder.sv
module stor_io_decoder
    import stor_dec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CMD_SIZE  = 8,
    parameter int CTL_SIZE  = 4,
    parameter int BM_SIZE   = 16,
    parameter int BM_SPLIT  = 8,
    parameter int DATA_OFF  = 0,
    parameter int SEL_OFF   = 6,
    parameter int DEV_BIT   = 4,
    parameter int IO_EN_BIT = 0,
    parameter int BM_EN_BIT = 2,
    parameter int CMD_W     = 16,
    parameter int OFF_W     = $clog2((BM_SIZE > CMD_SIZE) ?
                              ((BM_SIZE > CTL_SIZE) ? BM_SIZE : CTL_SIZE) :
                              ((CMD_SIZE > CTL_SIZE) ? CMD_SIZE : CTL_SIZE))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  host_cmd,
    input  logic              base_wr,
    input  logic [2:0]        base_idx,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic              acc_done,
    output logic [31:0]       acc_rdata,
    output logic [1:0]        acc_region,
    output logic              acc_chan,
    output logic [OFF_W-1:0]  acc_offset,
    output logic [1:0]        acc_drive,
    output logic              dec_err,
    input  logic [3:0]        drv_present,
    output logic              dx_valid,
    output logic              dx_write,
    output logic              dx_half,
    output logic [1:0]        dx_drive,
    output logic [1:0]        dx_region,
    output logic [OFF_W-1:0]  dx_offset,
    output logic [15:0]       dx_wdata,
    input  logic [15:0]       dx_rdata,
    output logic              bm_valid,
    output logic              bm_write,
    output logic              bm_chan,
    output logic [OFF_W-1:0]  bm_offset,
    output logic [1:0]        bm_size,
    output logic [31:0]       bm_wdata,
    input  logic [31:0]       bm_rdata
);

    localparam logic [31:0] ALL_ONES = '1;

    state_e state_q, state_d;

    // latched request
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_size;
    logic [31:0]       req_wdata;

    // registered decode results
    region_e           region_q;
    logic              chan_q;
    logic [OFF_W-1:0]  offset_q;
    logic [1:0]        drive_q;
    logic [31:0]       rdata_q;
    logic              err_q;
    logic              two_q;

    // decoder outputs
    logic              win_hit;
    region_e           win_rgn;
    logic              win_chan_s;
    logic [OFF_W-1:0]  win_off;
    logic [1:0]        sel_q;

    logic unused_cmd;
    assign unused_cmd = ^host_cmd;

    stor_win_decode #(
        .ADDR_W   (ADDR_W),
        .CMD_SIZE (CMD_SIZE),
        .CTL_SIZE (CTL_SIZE),
        .BM_SIZE  (BM_SIZE),
        .BM_SPLIT (BM_SPLIT),
        .OFF_W    (OFF_W)
    ) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_wr     (base_wr),
        .base_idx    (base_idx),
        .base_val    (base_val),
        .lookup_addr (req_addr),
        .hit         (win_hit),
        .region      (win_rgn),
        .chan        (win_chan_s),
        .offset      (win_off)
    );

    // decode-stage evaluation
    logic        io_en, bm_en, is_data, size_ok, sel_upd, sel_new;
    logic [1:0]  dec_drive;
    logic        dec_err_set;
    logic [31:0] dec_rdata;
    state_e      dec_next;

    always_comb begin
        io_en   = host_cmd[IO_EN_BIT];
        bm_en   = host_cmd[BM_EN_BIT];
        is_data = (win_rgn == RGN_CMD) && (win_off == OFF_W'(DATA_OFF));
        if (win_rgn == RGN_BM)
            size_ok = (req_size != 2'd3);
        else if (is_data)
            size_ok = (req_size == SZ_2) || (req_size == SZ_4);
        else
            size_ok = (req_size == SZ_1);

        sel_upd = win_hit && io_en && size_ok && req_write &&
                  (win_rgn == RGN_CMD) && (win_off == OFF_W'(SEL_OFF));
        sel_new   = sel_upd ? req_wdata[DEV_BIT] : sel_q[win_chan_s];
        dec_drive = {win_chan_s, sel_new};

        dec_err_set = 1'b0;
        dec_rdata   = '0;
        dec_next    = ST_DONE;
        if (!win_hit) begin
            dec_err_set = 1'b1;
            dec_rdata   = ALL_ONES;
        end else if (!io_en) begin
            dec_rdata   = '0;
        end else if (!size_ok) begin
            dec_err_set = 1'b1;
            dec_rdata   = ALL_ONES;
        end else if (win_rgn == RGN_BM) begin
            if (!(req_write && !bm_en))
                dec_next = ST_BM;
        end else if (drv_present[dec_drive]) begin
            dec_next = ST_DRV_LO;
        end
    end

    stor_drv_select #(.NUM_CH(2)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      ((state_q == ST_DECODE) && sel_upd),
        .upd_chan (win_chan_s),
        .upd_val  (req_wdata[DEV_BIT]),
        .sel_q    (sel_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_valid) state_d = ST_DECODE;
            ST_DECODE: state_d = dec_next;
            ST_DRV_LO: state_d = two_q ? ST_DRV_HI : ST_DONE;
            ST_DRV_HI: state_d = ST_DONE;
            ST_BM:     state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_write <= 1'b0;
            req_addr  <= '0;
            req_size  <= '0;
            req_wdata <= '0;
            region_q  <= RGN_NONE;
            chan_q    <= 1'b0;
            offset_q  <= '0;
            drive_q   <= '0;
            rdata_q   <= '0;
            err_q     <= 1'b0;
            two_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_valid) begin
                        req_write <= acc_write;
                        req_addr  <= acc_addr;
                        req_size  <= acc_size;
                        req_wdata <= acc_wdata;
                    end
                end
                ST_DECODE: begin
                    region_q <= win_rgn;
                    chan_q   <= win_chan_s;
                    offset_q <= win_off;
                    drive_q  <= win_hit ? dec_drive : 2'd0;
                    rdata_q  <= dec_rdata;
                    err_q    <= err_q | dec_err_set;
                    two_q    <= is_data && (req_size == SZ_4);
                end
                ST_DRV_LO: begin
                    if (req_size == SZ_1)
                        rdata_q <= {24'h0, dx_rdata[7:0]};
                    else
                        rdata_q <= {16'h0, dx_rdata};
                end
                ST_DRV_HI: rdata_q[31:16] <= dx_rdata;
                ST_BM: begin
                    case (req_size)
                        SZ_1:    rdata_q <= {24'h0, bm_rdata[7:0]};
                        SZ_2:    rdata_q <= {16'h0, bm_rdata[15:0]};
                        default: rdata_q <= bm_rdata;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        acc_ready  = (state_q == ST_IDLE);
        acc_done   = (state_q == ST_DONE);
        acc_rdata  = rdata_q;
        acc_region = region_q;
        acc_chan   = chan_q;
        acc_offset = offset_q;
        acc_drive  = drive_q;
        dec_err    = err_q;
        dx_valid   = (state_q == ST_DRV_LO) || (state_q == ST_DRV_HI);
        dx_half    = (state_q == ST_DRV_HI);
        dx_write   = req_write;
        dx_drive   = drive_q;
        dx_region  = region_q;
        dx_offset  = offset_q;
        dx_wdata   = (state_q == ST_DRV_HI) ? req_wdata[31:16] : req_wdata[15:0];
        bm_valid   = (state_q == ST_BM);
        bm_write   = req_write;
        bm_chan    = chan_q;
        bm_offset  = offset_q;
        bm_size    = req_size;
        bm_wdata   = req_wdata;
    end

endmodule

// File: rtl/stor_io_decoder_chk.sv
module stor_io_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] host_cmd,
    input logic        acc_valid,
    input logic        acc_ready,
    input logic        acc_done,
    input logic        dec_err,
    input logic [3:0]  drv_present,
    input logic        dx_valid,
    input logic        dx_half,
    input logic [1:0]  dx_drive,
    input logic        bm_valid,
    input logic        bm_write
);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |=> dec_err);

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> (!acc_done && acc_ready));

    assert_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> !acc_ready);

    assert_half_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dx_half |-> ($past(dx_valid) && !$past(dx_half)));

    assert_slot_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dx_valid |-> drv_present[dx_drive]);

    assert_bm_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_valid && bm_write) |-> $past(host_cmd[2]));

    assert_io_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dx_valid && !dx_half) |-> $past(host_cmd[0]));

endmodule

bind stor_io_decoder stor_io_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_cmd    (host_cmd),
    .acc_valid   (acc_valid),
    .acc_ready   (acc_ready),
    .acc_done    (acc_done),
    .dec_err     (dec_err),
    .drv_present (drv_present),
    .dx_valid    (dx_valid),
    .dx_half     (dx_half),
    .dx_drive    (dx_drive),
    .bm_valid    (bm_valid),
    .bm_write    (bm_write)
);

// File: tb/test_stor_io_decoder.sv
`timescale 1ns/1ps
module test_stor_io_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_cmd = '0;
    logic        base_wr = 1'b0;
    logic [2:0]  base_idx = '0;
    logic [15:0] base_val = '0;
    logic        acc_valid = 1'b0;
    logic        acc_ready;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_done;
    logic [31:0] acc_rdata;
    logic [1:0]  acc_region;
    logic        acc_chan;
    logic [3:0]  acc_offset;
    logic [1:0]  acc_drive;
    logic        dec_err;
    logic [3:0]  drv_present = 4'b0111;
    logic        dx_valid, dx_write, dx_half;
    logic [1:0]  dx_drive, dx_region;
    logic [3:0]  dx_offset;
    logic [15:0] dx_wdata, dx_rdata;
    logic        bm_valid, bm_write, bm_chan;
    logic [3:0]  bm_offset;
    logic [1:0]  bm_size;
    logic [31:0] bm_wdata, bm_rdata;

    always #2 clk = ~clk;

    assign dx_rdata = {4'hD, dx_half ? 4'h1 : 4'h0, 2'b00, dx_drive, dx_offset};
    assign bm_rdata = {8'hB5, 8'h00, 7'h0, bm_chan, 4'h0, bm_offset};

    stor_io_decoder i_stor_io_decoder (.*);

    int total = 0;
    int bad = 0;
    int dx_cnt = 0, bm_cnt = 0, done_cnt = 0;
    logic [15:0] dx_w0, dx_w1;
    logic [1:0]  dx_last_drive;
    logic        bm_last_chan;

    always @(posedge clk) begin
        if (dx_valid) begin
            dx_cnt <= dx_cnt + 1;
            dx_last_drive <= dx_drive;
            if (dx_half) dx_w1 <= dx_wdata; else dx_w0 <= dx_wdata;
        end
        if (bm_valid) begin
            bm_cnt <= bm_cnt + 1;
            bm_last_chan <= bm_chan;
        end
        if (acc_done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int d_dx, d_bm;

    task automatic access(input logic wr, input logic [15:0] addr,
                          input logic [1:0] sz, input logic [31:0] wd);
        int dx0, bm0, dn0;
        bit seen;
        @(negedge clk);
        dx0 = dx_cnt; bm0 = bm_cnt; dn0 = done_cnt;
        acc_valid = 1'b1; acc_write = wr; acc_addr = addr;
        acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            if (acc_done) seen = 1;
            else begin
                chk("R12 ready low while busy", {31'b0, acc_ready}, 32'd0);
                @(negedge clk);
            end
        end
        chk("R12 completion seen", {31'b0, seen}, 32'd1);
        d_dx = dx_cnt - dx0;
        d_bm = bm_cnt - bm0;
        @(negedge clk);
        chk("R12 one done pulse", done_cnt - dn0, 32'd1);
        @(negedge clk);
    endtask

    // sample helpers capture at done; results stay registered afterwards
    task automatic set_base(input logic [2:0] idx, input logic [15:0] v);
        @(negedge clk);
        base_wr = 1'b1; base_idx = idx; base_val = v;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ready", {31'b0, acc_ready}, 32'd1);
        chk("R1 err", {31'b0, dec_err}, 32'd0);
        chk("R1 no transfer", {30'b0, dx_valid, bm_valid}, 32'd0);
    endtask

    task automatic t_priority;
        host_cmd = 16'h0001;
        access(1'b0, 16'h0003, 2'd0, 0);
        chk("R2 overlap picks primary cmd", {30'b0, acc_region}, 32'd1);
        chk("R2 offset", {28'b0, acc_offset}, 32'd3);
        chk("R1 select bits zero", {30'b0, acc_drive}, 32'd0);
        chk("R2 read data", acc_rdata, 32'h03);
        access(1'b0, 16'h0009, 2'd2, 0);
        chk("R2 only bm covers 9", {30'b0, acc_region}, 32'd3);
        chk("R4 offset 9 is channel 1", {31'b0, acc_chan}, 32'd1);
        chk("R7 bm read with bm disabled", acc_rdata, 32'hB5000109);
    endtask

    task automatic t_bases;
        set_base(3'd0, 16'h01F0);
        set_base(3'd1, 16'h03F4);
        set_base(3'd2, 16'h0170);
        set_base(3'd3, 16'h0374);
        set_base(3'd4, 16'hC000);
        set_base(3'd0, 16'h0000);
        access(1'b0, 16'h01F2, 2'd0, 0);
        chk("R3 zero base ignored region", {30'b0, acc_region}, 32'd1);
        chk("R3 zero base ignored offset", {28'b0, acc_offset}, 32'd2);
        access(1'b0, 16'h0376, 2'd0, 0);
        chk("R2 sec ctl region", {30'b0, acc_region}, 32'd2);
        chk("R2 sec ctl chan", {31'b0, acc_chan}, 32'd1);
        chk("R2 sec ctl data", acc_rdata, 32'h22);
    endtask

    task automatic t_io_off;
        host_cmd = 16'h0000;
        access(1'b1, 16'h01F6, 2'd0, 32'h10);
        chk("R6 write no transfer", d_dx, 0);
        access(1'b0, 16'h01F7, 2'd0, 0);
        chk("R6 read zero", acc_rdata, 0);
        chk("R6 read no transfer", d_dx, 0);
        host_cmd = 16'h0001;
        access(1'b0, 16'h01F7, 2'd0, 0);
        chk("R6 select untouched", {30'b0, acc_drive}, 32'd0);
    endtask

    task automatic t_select;
        access(1'b1, 16'h01F6, 2'd0, 32'h10);
        chk("R5 write targets new slot", {30'b0, acc_drive}, 32'd1);
        chk("R5 select write forwarded", d_dx, 1);
        chk("R5 forwarded drive", {30'b0, dx_last_drive}, 32'd1);
        access(1'b0, 16'h01F7, 2'd0, 0);
        chk("R5 primary slot 1", acc_rdata, 32'h17);
        access(1'b0, 16'h0177, 2'd0, 0);
        chk("R5 secondary independent", acc_rdata, 32'h27);
        access(1'b1, 16'h01F6, 2'd0, 32'hEF);
        access(1'b0, 16'h01F7, 2'd0, 0);
        chk("R5 bit4 clear selects slot 0", {30'b0, acc_drive}, 32'd0);
    endtask

    task automatic t_data;
        access(1'b0, 16'h01F0, 2'd2, 0);
        chk("R9 4-byte read two transfers", d_dx, 2);
        chk("R9 4-byte read data", acc_rdata, 32'hD100D000);
        access(1'b1, 16'h01F0, 2'd1, 32'h1234ABCD);
        chk("R9 2-byte write one transfer", d_dx, 1);
        chk("R9 2-byte write data", {16'b0, dx_w0}, 32'hABCD);
        access(1'b1, 16'h01F0, 2'd2, 32'h5678CDEF);
        chk("R9 4-byte write two transfers", d_dx, 2);
        chk("R9 low half", {16'b0, dx_w0}, 32'hCDEF);
        chk("R9 high half", {16'b0, dx_w1}, 32'h5678);
    endtask

    task automatic t_miss_size;
        chk("R11 no error yet", {31'b0, dec_err}, 0);
        access(1'b0, 16'h5000, 2'd0, 0);
        chk("R11 region none", {30'b0, acc_region}, 0);
        chk("R11 read ones", acc_rdata, 32'hFFFFFFFF);
        chk("R11 error set", {31'b0, dec_err}, 1);
        access(1'b0, 16'h01F7, 2'd0, 0);
        chk("R11 error sticky", {31'b0, dec_err}, 1);
        access(1'b0, 16'h01F7, 2'd1, 0);
        chk("R10 2-byte to byte reg ones", acc_rdata, 32'hFFFFFFFF);
        chk("R10 no transfer", d_dx, 0);
        access(1'b0, 16'h01F0, 2'd0, 0);
        chk("R10 1-byte to data reg ones", acc_rdata, 32'hFFFFFFFF);
        chk("R10 data reg no transfer", d_dx, 0);
    endtask

    task automatic t_empty;
        access(1'b1, 16'h0176, 2'd0, 32'h10);
        chk("R8 slot 3 selected", {30'b0, acc_drive}, 3);
        chk("R8 write discarded", d_dx, 0);
        access(1'b0, 16'h0177, 2'd0, 0);
        chk("R8 read zero", acc_rdata, 0);
        chk("R8 read no transfer", d_dx, 0);
    endtask

    task automatic t_bm;
        host_cmd = 16'h0001;
        access(1'b1, 16'hC002, 2'd0, 32'h01);
        chk("R7 bm write dropped", d_bm, 0);
        host_cmd = 16'h0005;
        access(1'b1, 16'hC002, 2'd0, 32'h01);
        chk("R7 bm write passes", d_bm, 1);
        chk("R4 offset 2 channel 0", {31'b0, bm_last_chan}, 0);
        access(1'b1, 16'hC00C, 2'd2, 32'h0);
        chk("R4 offset 12 channel 1", {31'b0, bm_last_chan}, 1);
        chk("R4 offset reported", {28'b0, acc_offset}, 12);
        access(1'b0, 16'hC003, 2'd3, 0);
        chk("R10 illegal size code ones", acc_rdata, 32'hFFFFFFFF);
        chk("R10 no bm transfer", d_bm, 0);
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_priority;
        t_bases;
        t_io_off;
        t_select;
        t_data;
        t_miss_size;
        t_empty;
        t_bm;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule